// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Retransmit

This block is a single-clock FIFO controller for a 36-bit data path whose depth is a parameter. A read-timing mode is captured while master reset is held. In standard timing a read request moves the next stored word into the output register one edge later. In fall-through timing the oldest word is placed on the output register without any request, and a read request consumes it and brings the next one forward.

Five status outputs are computed from a registered count of the words held in storage. `rd_ok` reports data to read: in standard mode, at least one stored word; in fall-through mode, a valid word on `dout`. `wr_ok` reports free space. There is also a half-full flag and two threshold flags. The thresholds come in as offset values from a neighbouring block. A retransmit input rewinds reading to storage location zero, so the same data can be replayed. A partial reset clears the data path but keeps the latched mode.

Top module: `dual_mode_fifo`

## Requirements
- R1: `mode_sel` is sampled only while `rst_n` is low (1 = fall-through, 0 = standard). Changes after master reset has ended have no effect on the timing mode.
- R2: In standard mode, `rd_ok` is high exactly when at least one word is stored. A read (`ren` high while `rd_ok` is high) loads the oldest word into `dout` at that edge, in write order. `dout` does not change without a read.
- R3: In fall-through mode, a word written into an empty FIFO appears on `dout` with `rd_ok` high on the second edge after the write, with no read request. `ren` while `rd_ok` is high presents the next word at the next edge, or drops `rd_ok` if no word is stored.
- R4: `wr_ok` is low exactly when DEPTH words are stored. A write attempted then is discarded and never read out.
- R5: A read request when nothing is available leaves `dout` and the read position unchanged.
- R6: `half_full` is high exactly when the stored word count exceeds DEPTH/2. In fall-through mode the word held on `dout` is not counted.
- R7: `above_lo` is high when the stored count is at least `ae_ofs`, and low when it is below.
- R8: `above_hi` is high when the number of free locations (DEPTH minus the stored count) exceeds `af_ofs`, and low when it is at or below.
- R9: While `rst_n` is low, the pointers and the count are cleared and `dout` is zeroed. On release, `rd_ok` is low and `wr_ok` is high.
- R10: While `prst_n` is low, the pointers, the count and `dout` are cleared in the same way, and the latched mode is kept.
- R11: `rt` high at an edge sets the read position to location zero. `rd_ok` is low for the following cycle. Afterwards, reads replay from the first word written since reset. The write position is untouched, so later writes follow the earlier data.
- R12: The flags reflect a read or write at the clock edge that performs it, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, synchronous, active low; latches the mode |
| prst_n | input | 1 | Partial reset, synchronous, active low; keeps the mode |
| mode_sel | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| wen | input | 1 | Write request |
| din | input | 36 | Write data |
| ren | input | 1 | Read request |
| rt | input | 1 | Retransmit: rewind reading to location zero |
| ae_ofs | input | AW+1 | Almost-empty threshold n |
| af_ofs | input | AW+1 | Almost-full threshold m (in free locations) |
| dout | output | 36 | Output register |
| rd_ok | output | 1 | Data available (standard) / output valid (fall-through) |
| wr_ok | output | 1 | Space available to write |
| half_full | output | 1 | Stored count above DEPTH/2 |
| above_lo | output | 1 | Stored count at or above `ae_ofs` |
| above_hi | output | 1 | Free locations above `af_ofs` |

## Verification
The hardest situation to reach is a retransmit after part of the data has already been read, followed by new writes. Only then does the replayed sequence show that the read position returned to zero while the write position stayed put. The stimulus writes five words, reads two, pulses `rt`, checks the one-cycle `rd_ok` gap, and writes one more word. It then expects all six words in order. Threshold crossings are also checked in the cycle before the write edge, to show that the flags move only with the registered count.

// File: rtl/dmf_pkg.sv
// Shared types for the dual-mode FIFO.
package dmf_pkg;
    // Read-timing mode captured during master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dmf_store.sv
// Storage array: synchronous write, combinational read at the read address.
// Assumes the controller never writes a location that is being read out.
module dmf_store #(
    parameter int W     = 36,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    // Write port: store one word per accepted write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_ctrl.sv
// Pointer and occupancy control. Decides when a write is accepted and when a word
// leaves storage for the output register in each mode. It also handles retransmit.
// Assumes fewer than DEPTH words were written since reset when retransmit is used.
module dmf_ctrl
    import dmf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  rd_mode_e      mode,
    input  logic          wen,
    input  logic          ren,
    input  logic          rt,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] cnt,
    output logic          wr_go,
    output logic          pop,
    output logic          ovalid,
    output logic          rt_hold
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic clr;
    logic have;
    logic drop;

    assign clr   = !rst_n || !prst_n;
    assign have  = (cnt != '0) && !rt_hold && !rt;
    assign wr_go = wen && (cnt != FULL_CNT);

    // Pop selection: on request in standard mode, whenever the output is free in fall-through mode.
    always_comb begin
        if (mode == MODE_FWFT) begin
            pop  = have && (!ovalid || ren);
            drop = ren && ovalid && !pop && !rt;
        end else begin
            pop  = have && ren;
            drop = 1'b0;
        end
    end

    // Pointer, count and output-valid state.
    always_ff @(posedge clk) begin
        if (clr) begin
            wptr    <= '0;
            rptr    <= '0;
            cnt     <= '0;
            ovalid  <= 1'b0;
            rt_hold <= 1'b0;
        end else begin
            wptr <= wptr + AW'(wr_go);
            if (rt) begin
                rptr    <= '0;
                cnt     <= CW'(wptr) + CW'(wr_go);
                ovalid  <= 1'b0;
                rt_hold <= 1'b1;
            end else begin
                rptr    <= rptr + AW'(pop);
                cnt     <= cnt + CW'(wr_go) - CW'(pop);
                rt_hold <= 1'b0;
                if (pop) begin
                    ovalid <= 1'b1;
                end else if (drop) begin
                    ovalid <= 1'b0;
                end
            end
        end
    end

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (clr)
        cnt <= FULL_CNT);

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (cnt == FULL_CNT && !rt) |=> $stable(wptr));

    // R5
    empty_hold_chk: assert property (@(posedge clk) disable iff (clr)
        (cnt == '0 && !rt) |=> $stable(rptr));

    // R11
    rewind_chk: assert property (@(posedge clk) disable iff (clr)
        rt |=> (rptr == '0 && rt_hold && !ovalid));
endmodule

// File: rtl/dmf_flags.sv
// Status decode from the registered stored-word count and the two offsets.
// Assumes the count never exceeds DEPTH.
module dmf_flags #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] ae_ofs,
    input  logic [CW-1:0] af_ofs,
    output logic          wr_ok,
    output logic          half_full,
    output logic          above_lo,
    output logic          above_hi
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] free_cnt;

    // Threshold comparisons against the registered count.
    always_comb begin
        free_cnt  = FULL_CNT - cnt;
        wr_ok     = (cnt != FULL_CNT);
        half_full = (cnt > HALF_CNT);
        above_lo  = (cnt >= ae_ofs);
        above_hi  = (free_cnt > af_ofs);
    end
endmodule

// File: rtl/dual_mode_fifo.sv
// Dual-mode FIFO top: mode latch, output register, and wiring of storage, control and flags.
// Assumes DEPTH is a power of two and that offsets stay within 0..DEPTH.
module dual_mode_fifo
    import dmf_pkg::*;
#(
    parameter int W     = 36,
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prst_n,
    input  logic          mode_sel,
    input  logic          wen,
    input  logic [W-1:0]  din,
    input  logic          ren,
    input  logic          rt,
    input  logic [CW-1:0] ae_ofs,
    input  logic [CW-1:0] af_ofs,
    output logic [W-1:0]  dout,
    output logic          rd_ok,
    output logic          wr_ok,
    output logic          half_full,
    output logic          above_lo,
    output logic          above_hi
);
    rd_mode_e      mode;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] cnt;
    logic          wr_go;
    logic          pop;
    logic          ovalid;
    logic          rt_hold;
    logic [W-1:0]  rdata;

    // Mode latch: follows mode_sel only while master reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= rd_mode_e'(mode_sel);
        end
    end

    // Output register: cleared by either reset, loaded on every pop.
    always_ff @(posedge clk) begin
        if (!rst_n || !prst_n) begin
            dout <= '0;
        end else if (pop) begin
            dout <= rdata;
        end
    end

    assign rd_ok = (mode == MODE_FWFT) ? ovalid : ((cnt != '0) && !rt_hold);

    dmf_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk   (clk),
        .we    (wr_go),
        .waddr (wptr),
        .wdata (din),
        .raddr (rptr),
        .rdata (rdata)
    );

    dmf_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .prst_n  (prst_n),
        .mode    (mode),
        .wen     (wen),
        .ren     (ren),
        .rt      (rt),
        .wptr    (wptr),
        .rptr    (rptr),
        .cnt     (cnt),
        .wr_go   (wr_go),
        .pop     (pop),
        .ovalid  (ovalid),
        .rt_hold (rt_hold)
    );

    dmf_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .cnt       (cnt),
        .ae_ofs    (ae_ofs),
        .af_ofs    (af_ofs),
        .wr_ok     (wr_ok),
        .half_full (half_full),
        .above_lo  (above_lo),
        .above_hi  (above_hi)
    );

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode));

    // R11
    rt_gap_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        rt |=> !rd_ok);

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n || !prst_n)
        !pop |=> $stable(dout));
endmodule

// File: tb/dual_mode_fifo_test.sv
// Directed bench for dual_mode_fifo: one task per scenario, each checking its own results.
module dual_mode_fifo_test;
    localparam int W     = 36;
    localparam int DEPTH = 16;
    localparam int CW    = $clog2(DEPTH) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic          wen = 1'b0;
    logic [W-1:0]  din = '0;
    logic          ren = 1'b0;
    logic          rt = 1'b0;
    logic [CW-1:0] ae_ofs = CW'(2);
    logic [CW-1:0] af_ofs = CW'(2);
    logic [W-1:0]  dout;
    logic          rd_ok;
    logic          wr_ok;
    logic          half_full;
    logic          above_lo;
    logic          above_hi;

    int checks = 0;
    int errors = 0;

    dual_mode_fifo #(.W(W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .prst_n(prst_n), .mode_sel(mode_sel),
        .wen(wen), .din(din), .ren(ren), .rt(rt),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs), .dout(dout), .rd_ok(rd_ok),
        .wr_ok(wr_ok), .half_full(half_full), .above_lo(above_lo), .above_hi(above_hi)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [W-1:0] v);
        wen = 1'b1;
        din = v;
        step();
        wen = 1'b0;
    endtask

    task automatic master_reset(input logic m);
        mode_sel = m;
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        mode_sel = ~m;
    endtask

    task automatic partial_reset();
        prst_n = 1'b0;
        step();
        prst_n = 1'b1;
    endtask

    task automatic t_reset();
        master_reset(1'b0);
        chk("R9 rd_ok", W'(rd_ok), W'(0));
        chk("R9 wr_ok", W'(wr_ok), W'(1));
        chk("R9 dout", dout, W'(0));
        chk("R9 half_full", W'(half_full), W'(0));
    endtask

    task automatic t_std_order();
        push(W'('h0A));
        push(W'('h0B));
        push(W'('h0C));
        chk("R2 rd_ok stored", W'(rd_ok), W'(1));
        chk("R2 dout before read", dout, W'(0));
        ren = 1'b1;
        step();
        chk("R2 first", dout, W'('h0A));
        step();
        chk("R2 second", dout, W'('h0B));
        step();
        chk("R2 third", dout, W'('h0C));
        chk("R2 rd_ok drained", W'(rd_ok), W'(0));
        step();
        chk("R5 empty read dout", dout, W'('h0C));
        ren = 1'b0;
    endtask

    task automatic t_full();
        partial_reset();
        for (int i = 0; i < DEPTH; i++) begin
            push(W'('h100 + i));
            if (i == DEPTH - 2) chk("R4 wr_ok one short", W'(wr_ok), W'(1));
        end
        chk("R4 wr_ok full", W'(wr_ok), W'(0));
        chk("R6 half_full full", W'(half_full), W'(1));
        chk("R8 above_hi full", W'(above_hi), W'(0));
        push(W'('hBAD));
        ren = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            step();
            chk("R4 drain order", dout, W'('h100 + i));
        end
        step();
        chk("R5 read past empty", dout, W'('h100 + DEPTH - 1));
        chk("R4 discarded write", W'(rd_ok), W'(0));
        ren = 1'b0;
    endtask

    task automatic t_flags();
        ae_ofs = CW'(4);
        af_ofs = CW'(3);
        partial_reset();
        for (int i = 0; i < 3; i++) push(W'(i));
        chk("R7 below n", W'(above_lo), W'(0));
        wen = 1'b1;
        din = W'(3);
        #1;
        chk("R12 before edge", W'(above_lo), W'(0));
        step();
        wen = 1'b0;
        chk("R7 at n", W'(above_lo), W'(1));
        for (int i = 4; i < 8; i++) push(W'(i));
        chk("R6 at half", W'(half_full), W'(0));
        push(W'(8));
        chk("R6 above half", W'(half_full), W'(1));
        for (int i = 9; i < 12; i++) push(W'(i));
        chk("R8 free above m", W'(above_hi), W'(1));
        push(W'(12));
        chk("R8 free at m", W'(above_hi), W'(0));
        af_ofs = CW'(2);
        #1;
        chk("R8 lower m", W'(above_hi), W'(1));
        ae_ofs = CW'(2);
        af_ofs = CW'(2);
    endtask

    task automatic t_retransmit();
        partial_reset();
        for (int i = 0; i < 5; i++) push(W'('h200 + i));
        ren = 1'b1;
        step();
        step();
        ren = 1'b0;
        chk("R11 partial read", dout, W'('h201));
        rt = 1'b1;
        step();
        rt = 1'b0;
        chk("R11 gap", W'(rd_ok), W'(0));
        step();
        chk("R11 after gap", W'(rd_ok), W'(1));
        push(W'('h205));
        ren = 1'b1;
        for (int i = 0; i < 6; i++) begin
            step();
            chk("R11 replay", dout, W'('h200 + i));
        end
        ren = 1'b0;
        chk("R11 drained", W'(rd_ok), W'(0));
    endtask

    task automatic t_fwft();
        master_reset(1'b1);
        chk("R9 fwft dout", dout, W'(0));
        chk("R9 fwft rd_ok", W'(rd_ok), W'(0));
        push(W'('h300));
        chk("R3 not yet", W'(rd_ok), W'(0));
        step();
        chk("R3 fall through", dout, W'('h300));
        chk("R1 mode kept", W'(rd_ok), W'(1));
        push(W'('h301));
        chk("R3 held", dout, W'('h300));
        ren = 1'b1;
        step();
        chk("R3 advance", dout, W'('h301));
        step();
        ren = 1'b0;
        chk("R3 consumed", W'(rd_ok), W'(0));
        push(W'('h302));
        step();
        chk("R3 refill", dout, W'('h302));
        partial_reset();
        chk("R10 dout cleared", dout, W'(0));
        chk("R10 rd_ok cleared", W'(rd_ok), W'(0));
        push(W'('h303));
        step();
        chk("R10 mode kept", dout, W'('h303));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_std_order();
        t_full();
        t_flags();
        t_retransmit();
        t_fwft();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule